// File: doc/BRIEF.md
# External Bus Turnaround Wait Scheduler

This block sits in front of a static external memory controller. It decides in which cycle the next access may start on the shared data bus. Each access arrives on a valid/ready request carrying a chip select, a direction and a flag that marks it as internal. The block answers with a combinational grant. While it holds a valid request back, it raises busy.

Each chip select has its own configuration, written through a small configuration port: a 4-bit bus-release count, a bit choosing which strobe starts the release window, and a bit that lets a read to the same device skip the window. After an external read, the access engine signals the rising edge of the read strobe and of the chip select. The block loads a release counter on the edge chosen for that device and counts it down. Depending on the kind of the next access, that access either waits for the counter or ignores it.

Independently of the release counter, the block also enforces a fixed turnaround gap between an external read and a following external write. It also inserts one reload cycle whenever the slow-clock mode input changes.

Top module: `bus_turn_sched`

## Requirements
- R1: After reset, busy and grant are 0. The first external request is granted in the same cycle it is presented.
- R2: For a chip select whose strobe-select bit is 1, a read-strobe edge pulse in cycle e loads its release count N. An external write presented from cycle e+1 is granted in cycle e+1+N.
- R3: For a chip select whose strobe-select bit is 0, only the chip-select edge pulse starts the window. A read-strobe pulse has no effect, so the next write is granted at once.
- R4: An external read to a chip select other than the one last read waits for the release counter to reach zero.
- R5: Every external write waits for the release counter to reach zero, whether it targets the last-read chip select or another one.
- R6: A request with the internal flag set is granted in the cycle it is presented. Release window, turnaround and reload cycles do not affect it.
- R7: A read to the last-read chip select skips the release window when that chip select's skip bit is 1. When the bit is 0, the read waits like any other read.
- R8: A release count of 0 adds no wait. A write presented in the cycle after the edge pulse is granted in that cycle.
- R9: An external write presented in the cycle right after an external read grant is stalled exactly one cycle. Read after read, and read after write, are not stalled.
- R10: A change of the slow-clock mode input during cycle t blocks external grants in cycle t+1 only.
- R11: The reload cycle does not count toward the turnaround gap. A read granted together with a mode change, followed at once by a write, gives that write two stall cycles.
- R12: busy is 1 exactly when a valid request is not granted. A stalled request keeps its fields stable until it is granted.
- R13: A configuration write for one chip select takes effect from the next cycle and leaves the other chip selects unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Chip select being configured |
| cfg_flt | input | 4 | Bus-release cycle count |
| cfg_rdctl | input | 1 | 1: window starts at the read-strobe edge; 0: at the chip-select edge |
| cfg_skip | input | 1 | 1: same-device reads skip the window |
| rd_rise | input | 1 | Read-strobe rising-edge pulse from the access engine |
| cs_rise | input | 1 | Chip-select rising-edge pulse from the access engine |
| slow_mode | input | 1 | Slow-clock mode level |
| req_valid | input | 1 | Request valid |
| req_cs | input | 2 | Request chip select |
| req_wr | input | 1 | 1 write, 0 read |
| req_int | input | 1 | 1 internal access, not on the external bus |
| grant | output | 1 | Request accepted this cycle |
| busy | output | 1 | Valid request being stalled |

## Verification
The bench measures each grant latency against the cycle of the strobe pulse, which exposes any off-by-one in loading or draining the release counter. A count of 0 is included, because a design that always adds one cycle would show up there. It swaps the device's strobe select to show that a design listening to the wrong edge grants too early. It contrasts same-device reads with the skip bit set and cleared, and reads to a different device, to catch a design that skips the window too widely or too narrowly. It places a mode change together with a read grant, so a design that lets the reload cycle overlap the turnaround gap grants a write one cycle early.

// File: rtl/bts_pkg.sv
package bts_pkg;

  parameter int FLOAT_W = 4;

  typedef struct packed {
    logic [FLOAT_W-1:0] flt;
    logic               rdctl;
    logic               skip;
  } cs_cfg_t;

  // does a pending release window hold back this external access?
  function automatic logic window_applies(input logic wr, input logic same_cs,
                                          input logic skip);
    return wr | ~same_cs | ~skip;
  endfunction

  // next release counter value
  function automatic logic [FLOAT_W-1:0] cnt_next(input logic hit,
                                                  input logic [FLOAT_W-1:0] load,
                                                  input logic [FLOAT_W-1:0] cur);
    if (hit)
      return load;
    else if (cur != '0)
      return cur - 1'b1;
    else
      return cur;
  endfunction

  // turnaround needed when a write follows a read before the gap has elapsed
  function automatic logic turn_needed(input logic wr, input logic last_rd,
                                       input logic gap_ok);
    return wr & last_rd & ~gap_ok;
  endfunction

endpackage

// File: rtl/bts_cfg_bank.sv
module bts_cfg_bank
  import bts_pkg::*;
#(
  parameter int NCS = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CSW-1:0]       sel,
  input  cs_cfg_t              wdata,
  output cs_cfg_t [NCS-1:0]    cfg
);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg[i] <= '0;
      else if (we && (sel == CSW'(i)))
        cfg[i] <= wdata;
    end
  end

endmodule

// File: rtl/bts_float_trk.sv
module bts_float_trk
  import bts_pkg::*;
#(
  parameter int NCS = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_grant,
  input  logic [CSW-1:0]    grant_cs,
  input  cs_cfg_t [NCS-1:0] cfg,
  input  logic              rd_rise,
  input  logic              cs_rise,
  output logic [CSW-1:0]    last_cs,
  output logic              win_idle,
  output logic              edge_hit
);

  logic               seen;
  logic [FLOAT_W-1:0] cnt;
  cs_cfg_t            cur_cfg;

  assign cur_cfg  = cfg[last_cs];
  assign edge_hit = seen & (cur_cfg.rdctl ? rd_rise : cs_rise);
  assign win_idle = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_cs <= '0;
      seen    <= 1'b0;
      cnt     <= '0;
    end else begin
      if (rd_grant) begin
        last_cs <= grant_cs;
        seen    <= 1'b1;
      end
      cnt <= cnt_next(edge_hit, cur_cfg.flt, cnt);
    end
  end

endmodule

// File: rtl/bts_gap_trk.sv
module bts_gap_trk
  import bts_pkg::*;
#(
  parameter int TURN_CYC = 1,
  localparam int GW = $clog2(TURN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_grant,
  input  logic grant_wr,
  input  logic slow_mode,
  output logic last_rd,
  output logic gap_ok,
  output logic rl_pend
);

  localparam logic [GW-1:0] TC = GW'(TURN_CYC);

  logic          slow_q;
  logic          mode_chg;
  logic [GW-1:0] gap_cnt;

  assign mode_chg = slow_mode ^ slow_q;
  assign gap_ok   = (gap_cnt == TC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_q  <= 1'b0;
      rl_pend <= 1'b0;
      last_rd <= 1'b0;
      gap_cnt <= TC;
    end else begin
      slow_q  <= slow_mode;
      rl_pend <= mode_chg;
      if (ext_grant) begin
        last_rd <= ~grant_wr;
        gap_cnt <= '0;
      end else if (!rl_pend && !gap_ok) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_turn_sched.sv
module bus_turn_sched
  import bts_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int TURN_CYC = 1,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CSW-1:0]     cfg_sel,
  input  logic [FLOAT_W-1:0] cfg_flt,
  input  logic               cfg_rdctl,
  input  logic               cfg_skip,
  input  logic               rd_rise,
  input  logic               cs_rise,
  input  logic               slow_mode,
  input  logic               req_valid,
  input  logic [CSW-1:0]     req_cs,
  input  logic               req_wr,
  input  logic               req_int,
  output logic               grant,
  output logic               busy
);

  cs_cfg_t [NCS-1:0] cfg;
  cs_cfg_t           wdata;
  logic [CSW-1:0]    last_cs;
  logic              win_idle;
  logic              edge_hit;
  logic              last_rd;
  logic              gap_ok;
  logic              rl_pend;
  logic              ext_grant;
  logic              win_block;
  logic              turn_block;
  logic              ext_ok;

  assign wdata = '{flt: cfg_flt, rdctl: cfg_rdctl, skip: cfg_skip};

  bts_cfg_bank #(.NCS(NCS)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (wdata),
    .cfg   (cfg)
  );

  bts_float_trk #(.NCS(NCS)) u_flt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_grant (ext_grant & ~req_wr),
    .grant_cs (req_cs),
    .cfg      (cfg),
    .rd_rise  (rd_rise),
    .cs_rise  (cs_rise),
    .last_cs  (last_cs),
    .win_idle (win_idle),
    .edge_hit (edge_hit)
  );

  bts_gap_trk #(.TURN_CYC(TURN_CYC)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_grant (ext_grant),
    .grant_wr  (req_wr),
    .slow_mode (slow_mode),
    .last_rd   (last_rd),
    .gap_ok    (gap_ok),
    .rl_pend   (rl_pend)
  );

  assign win_block  = ~win_idle & window_applies(req_wr, req_cs == last_cs,
                                                 cfg[last_cs].skip);
  assign turn_block = turn_needed(req_wr, last_rd, gap_ok);
  assign ext_ok     = ~win_block & ~turn_block & ~rl_pend;
  assign grant      = req_valid & (req_int | ext_ok);
  assign busy       = req_valid & ~grant;
  assign ext_grant  = grant & ~req_int;

endmodule

// File: rtl/bus_turn_sched_chk.sv
module bus_turn_sched_chk #(
  parameter int NCS = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [CSW-1:0] req_cs,
  input logic           req_wr,
  input logic           req_int,
  input logic           grant,
  input logic           busy,
  input logic           slow_mode,
  input logic           win_idle,
  input logic           rl_pend
);

  // R6
  int_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_int) |-> grant);

  // R5
  float_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_idle && req_valid && !req_int && req_wr) |-> !grant);

  // R9
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !req_int && !req_wr) |=> !(grant && !req_int && req_wr));

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode != $past(slow_mode)) |=> !(grant && !req_int));

  // R10
  reload_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rl_pend |=> (!rl_pend || (slow_mode != $past(slow_mode))));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !grant) |=> (req_valid && $stable(req_cs) && $stable(req_wr)
                               && $stable(req_int)));

  // R12
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req_valid && !grant));

endmodule

bind bus_turn_sched bus_turn_sched_chk #(.NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_cs    (req_cs),
  .req_wr    (req_wr),
  .req_int   (req_int),
  .grant     (grant),
  .busy      (busy),
  .slow_mode (slow_mode),
  .win_idle  (win_idle),
  .rl_pend   (rl_pend)
);

// File: tb/sim_bus_turn_sched.sv
module sim_bus_turn_sched;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [3:0] cfg_flt = '0;
  logic       cfg_rdctl = 1'b0;
  logic       cfg_skip = 1'b0;
  logic       rd_rise = 1'b0;
  logic       cs_rise = 1'b0;
  logic       slow_mode = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_cs = '0;
  logic       req_wr = 1'b0;
  logic       req_int = 1'b0;
  logic       grant;
  logic       busy;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  int    q_start[$];
  int    q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  bus_turn_sched u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_flt(cfg_flt), .cfg_rdctl(cfg_rdctl), .cfg_skip(cfg_skip),
    .rd_rise(rd_rise), .cs_rise(cs_rise), .slow_mode(slow_mode),
    .req_valid(req_valid), .req_cs(req_cs), .req_wr(req_wr),
    .req_int(req_int), .grant(grant), .busy(busy)
  );

  // monitor: compares grant latency with the scoreboard, and busy with stalls
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (busy !== !grant) begin
        checks++; errors++;
        $display("FAIL R12 busy=%0b expected %0b", busy, !grant);
      end
      if (grant) begin
        int st, ex, act;
        string tg;
        st = q_start.pop_front(); ex = q_exp.pop_front(); tg = q_tag.pop_front();
        act = cyc - st;
        checks++;
        if (act != ex) begin
          errors++;
          $display("FAIL %s wait=%0d expected %0d", tg, act, ex);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cfg_wr(logic [1:0] cs, logic [3:0] flt, logic rdctl, logic skip);
    cfg_we = 1'b1; cfg_sel = cs; cfg_flt = flt; cfg_rdctl = rdctl; cfg_skip = skip;
    step(1);
    cfg_we = 1'b0;
  endtask

  // driver: presents a request, pushes its expected wait, holds until granted
  task automatic issue(logic [1:0] cs, logic wr, logic intl, int exp_wait, string tag);
    req_valid = 1'b1; req_cs = cs; req_wr = wr; req_int = intl;
    q_start.push_back(cyc); q_exp.push_back(exp_wait); q_tag.push_back(tag);
    forever begin
      @(negedge clk);
      if (grant) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_rise = 1'b1; step(1); rd_rise = 1'b0;
  endtask

  task automatic pulse_cs();
    cs_rise = 1'b1; step(1); cs_rise = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    @(negedge clk);
    checks++;
    if (grant !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset grant=%0b busy=%0b expected 0 0", grant, busy);
    end
    @(posedge clk); #1;

    // R13 per-device configuration
    cfg_wr(2'd0, 4'd3, 1'b1, 1'b0);
    cfg_wr(2'd1, 4'd2, 1'b0, 1'b1);
    cfg_wr(2'd2, 4'd0, 1'b1, 1'b0);

    issue(2'd0, 1'b0, 1'b0, 0, "R1 first read");
    pulse_rd();
    issue(2'd0, 1'b1, 1'b0, 3, "R2 write after read-strobe window");
    step(6);

    issue(2'd1, 1'b0, 1'b0, 0, "R3 read cs1");
    pulse_rd();
    issue(2'd2, 1'b1, 1'b0, 0, "R3 read strobe ignored");
    issue(2'd1, 1'b0, 1'b0, 0, "R3 read cs1 again");
    pulse_cs();
    issue(2'd0, 1'b1, 1'b0, 2, "R3 chip-select window R13");
    step(6);

    issue(2'd0, 1'b0, 1'b0, 0, "R4 read cs0");
    pulse_rd();
    issue(2'd1, 1'b0, 1'b0, 3, "R4 read other device");
    pulse_cs();
    issue(2'd1, 1'b0, 1'b0, 0, "R7 skip bit same device");
    step(6);

    issue(2'd0, 1'b0, 1'b0, 0, "R7 read cs0");
    pulse_rd();
    issue(2'd0, 1'b0, 1'b0, 3, "R7 no skip same device");
    step(6);

    issue(2'd0, 1'b0, 1'b0, 0, "R6 read cs0");
    pulse_rd();
    issue(2'd0, 1'b1, 1'b1, 0, "R6 internal inside window");
    issue(2'd0, 1'b1, 1'b0, 2, "R5 write same device");
    step(6);

    issue(2'd0, 1'b0, 1'b0, 0, "R5 read cs0");
    pulse_rd();
    issue(2'd3, 1'b1, 1'b0, 3, "R5 write other device");
    step(6);

    issue(2'd2, 1'b0, 1'b0, 0, "R8 read cs2");
    pulse_rd();
    issue(2'd2, 1'b1, 1'b0, 0, "R8 zero release count");
    step(6);

    issue(2'd3, 1'b0, 1'b0, 0, "R9 read cs3");
    issue(2'd3, 1'b1, 1'b0, 1, "R9 write right after read");
    issue(2'd3, 1'b0, 1'b0, 0, "R9 read after write");
    issue(2'd3, 1'b0, 1'b0, 0, "R9 read after read");
    step(6);

    slow_mode = 1'b1;
    step(1);
    issue(2'd3, 1'b0, 1'b0, 1, "R10 reload cycle");
    step(4);
    slow_mode = 1'b0;
    step(1);
    issue(2'd3, 1'b0, 1'b1, 0, "R6 R10 internal in reload cycle");
    step(6);

    slow_mode = 1'b1;
    issue(2'd3, 1'b0, 1'b0, 0, "R11 read with mode change");
    issue(2'd3, 1'b1, 1'b0, 2, "R11 reload plus turnaround");
    step(4);

    if (q_start.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12 outstanding=%0d expected 0", q_start.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog cycles=%0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule